// File: doc/BRIEF.md
# Watchdog Timer with Safe-Frequency Fallback

This block supervises a system through a watchdog counter that advances only on a slow time-base tick. Each tick stands for one timeout unit, nominally 290 ms, and the bench drives it from a fast pulse. Software arms the watchdog and sets its timeout through a single configuration word. It then services the watchdog with a kick pulse. If no kick arrives before the programmed number of ticks has passed, the block raises alarms in stages. With the soft stage enabled, the first expiry only sets a soft-alarm status bit and restarts the count. The next expiry, or the first one when the soft stage is off, is a hard alarm.

A hard alarm does two things. It drives the active-low system reset output low for a fixed number of ticks. It also overrides the frequency select sent to the clock synthesiser with a safe value. That safe value is either the select latched at power-up or a programmed safe select, chosen by a mode bit. Separately, when gear-shift reset is enabled, any change of the requested frequency select also produces a reset pulse of the same length.

Top module: `clkwd_guard`

## Requirements
- R1: After reset the readback word is 13'h0201, sys_rst_n is 1, both alarms are 0 and fs_out equals fs_req. The word layout is en[12], soft_en[11], safe_mode[10], timeout[9:5] and safe_sel[4:0], so the defaults are disabled, soft stage off, latched mode, timeout 16 and safe select 00001.
- R2: While en is 0, ticks raise no alarm and leave sys_rst_n high.
- R3: With en set and the soft stage off, hard_alarm rises on the T-th tick after a configuration write, where T is the timeout field. A timeout of 0 expires on the first tick.
- R4: A kick reloads the count, so the hard alarm comes T ticks after the last kick.
- R5: With soft_en set, soft_alarm rises on the first expiry (tick T) while sys_rst_n stays high. The count restarts and the hard alarm follows T ticks later.
- R6: On the hard alarm, sys_rst_n goes low at the same clock edge. It stays low for exactly RST_TICKS ticks.
- R7: From the cycle after the hard alarm, fs_out carries the safe select: safe_sel when safe_mode is 1, fs_latched when safe_mode is 0.
- R8: A configuration write clears both alarms, restarts the count from the new timeout and updates the readback word. On the next cycle fs_out returns to fs_req.
- R9: With gear_rst_en at 1, a change of fs_req pulls sys_rst_n low for RST_TICKS ticks. With gear_rst_en at 0, a change produces no pulse. In both cases fs_out follows one cycle later.
- R10: A hard alarm is sticky until the next configuration write. Kicks and further ticks neither clear it nor start another reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse, one timeout unit |
| kick | input | 1 | Watchdog service pulse |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word to write |
| cfg_rdata | output | 13 | Configuration word readback |
| gear_rst_en | input | 1 | Enable reset pulse on frequency select change |
| fs_req | input | 5 | Frequency select requested by the normal path |
| fs_latched | input | 5 | Frequency select latched at power-up |
| fs_out | output | 5 | Frequency select in force |
| sys_rst_n | output | 1 | Active-low system reset output |
| soft_alarm | output | 1 | Soft alarm status |
| hard_alarm | output | 1 | Hard alarm status |

## Verification
On every cycle the assertions check four things. Alarms and reset edges happen only on ticks. The hard alarm stays set until a write. The reset output falls only when a hard alarm or a gear change starts it. Once the hard alarm has been in force for a cycle, fs_out matches the chosen safe select. Only the bench scenarios can show the exact tick counts: timeout length including the zero case, reload by kick, the two-stage soft path and the width of the reset pulse. The bench also covers power-up defaults and the difference between gear-shift reset enabled and disabled.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;
  localparam int TO_W  = 5;
  localparam int FS_W  = 5;
  localparam int CFG_W = 3 + TO_W + FS_W;

  typedef struct packed {
    logic            en;
    logic            soft_en;
    logic            safe_mode;
    logic [TO_W-1:0] timeout;
    logic [FS_W-1:0] safe_sel;
  } cfg_t;
endpackage

// File: rtl/clkwd_cfg.sv
module clkwd_cfg
  import clkwd_pkg::*;
#(
  parameter logic [TO_W-1:0] DEF_TO   = 5'd16,
  parameter logic [FS_W-1:0] DEF_SAFE = 5'd1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  cfg_t wdata,
  output cfg_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q.en        <= 1'b0;
      q.soft_en   <= 1'b0;
      q.safe_mode <= 1'b0;
      q.timeout   <= DEF_TO;
      q.safe_sel  <= DEF_SAFE;
    end else if (wr) begin
      q <= wdata;
    end
  end
endmodule

// File: rtl/clkwd_timer.sv
module clkwd_timer
  import clkwd_pkg::*;
#(
  parameter logic [TO_W-1:0] DEF_TO = 5'd16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            kick,
  input  logic            wr,
  input  logic [TO_W-1:0] wr_timeout,
  input  logic            en,
  input  logic            soft_en,
  input  logic [TO_W-1:0] timeout,
  output logic            soft_q,
  output logic            hard_q,
  output logic            hard_evt
);
  logic [TO_W-1:0] cnt_q;
  logic            expire;
  logic            to_hard;

  // A count of 0 or 1 expires on the next tick
  always_comb begin
    expire   = en && !hard_q && !kick && tick && (cnt_q <= TO_W'(1));
    to_hard  = expire && !(soft_en && !soft_q);
    hard_evt = to_hard && !wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= DEF_TO;
      soft_q <= 1'b0;
      hard_q <= 1'b0;
    end else if (wr) begin
      cnt_q  <= wr_timeout;
      soft_q <= 1'b0;
      hard_q <= 1'b0;
    end else if (!en || hard_q || kick) begin
      cnt_q <= timeout;
    end else if (expire) begin
      if (to_hard) begin
        hard_q <= 1'b1;
      end else begin
        soft_q <= 1'b1;
        cnt_q  <= timeout;
      end
    end else if (tick) begin
      cnt_q <= cnt_q - TO_W'(1);
    end
  end

  assert_hard_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_q) |-> $past(tick));
  assert_soft_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_q) |-> $past(tick) && $past(soft_en));
  assert_hard_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(hard_q) && !$past(wr) |-> hard_q);
endmodule

// File: rtl/clkwd_rstgen.sv
module clkwd_rstgen #(
  parameter int RST_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic rst_n_o
);
  localparam int CW = $clog2(RST_TICKS + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      rst_n_o <= 1'b1;
    end else if (start) begin
      left_q  <= CW'(RST_TICKS);
      rst_n_o <= 1'b0;
    end else if (tick && left_q != '0) begin
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) rst_n_o <= 1'b1;
    end
  end

  assert_fall_needs_start_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> $past(start));
  assert_rise_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(tick) && !$past(start));
endmodule

// File: rtl/clkwd_guard.sv
module clkwd_guard
  import clkwd_pkg::*;
#(
  parameter int              RST_TICKS = 4,
  parameter logic [TO_W-1:0] DEF_TO    = 5'd16,
  parameter logic [FS_W-1:0] DEF_SAFE  = 5'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             gear_rst_en,
  input  logic [FS_W-1:0]  fs_req,
  input  logic [FS_W-1:0]  fs_latched,
  output logic [FS_W-1:0]  fs_out,
  output logic             sys_rst_n,
  output logic             soft_alarm,
  output logic             hard_alarm
);
  cfg_t            cfg_q;
  cfg_t            wdata;
  logic            hard_evt;
  logic            gear_evt;
  logic [FS_W-1:0] safe_val;
  logic [FS_W-1:0] fs_q;
  logic [FS_W-1:0] req_q;

  assign wdata = cfg_t'(cfg_wdata);

  clkwd_cfg #(.DEF_TO(DEF_TO), .DEF_SAFE(DEF_SAFE)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(wdata), .q(cfg_q)
  );

  clkwd_timer #(.DEF_TO(DEF_TO)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick), .wr(cfg_wr),
    .wr_timeout(wdata.timeout), .en(cfg_q.en), .soft_en(cfg_q.soft_en),
    .timeout(cfg_q.timeout), .soft_q(soft_alarm), .hard_q(hard_alarm),
    .hard_evt(hard_evt)
  );

  clkwd_rstgen #(.RST_TICKS(RST_TICKS)) u_rstgen (
    .clk(clk), .rst(rst), .tick(tick), .start(hard_evt | gear_evt),
    .rst_n_o(sys_rst_n)
  );

  always_comb begin
    safe_val = cfg_q.safe_mode ? cfg_q.safe_sel : fs_latched;
    gear_evt = gear_rst_en && !hard_alarm && (fs_req != req_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q  <= fs_req;
      req_q <= fs_req;
    end else begin
      fs_q  <= hard_alarm ? safe_val : fs_req;
      req_q <= fs_req;
    end
  end

  assign fs_out    = fs_q;
  assign cfg_rdata = cfg_q;

  assert_safe_in_force_R7: assert property (@(posedge clk) disable iff (rst)
    hard_alarm && $past(hard_alarm) |-> fs_q == safe_val);
endmodule

// File: tb/clkwd_guard_bench.sv
module clkwd_guard_bench;
  localparam int RT = 3;
  localparam logic [4:0] REQ0 = 5'h13;
  localparam logic [4:0] LAT  = 5'h0A;

  // vector: timeout, soft_en, safe_mode, safe_sel
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {5'd3,  1'b0, 1'b0, 5'h1C},
    {5'd5,  1'b0, 1'b1, 5'h1F},
    {5'd0,  1'b0, 1'b1, 5'h07},
    {5'd2,  1'b1, 1'b1, 5'h15},
    {5'd1,  1'b1, 1'b0, 5'h00},
    {5'd31, 1'b0, 1'b1, 5'h02}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, kick = 1'b0, cfg_wr = 1'b0, gear_rst_en = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic [12:0] cfg_rdata;
  logic [4:0] fs_req = REQ0;
  logic [4:0] fs_out;
  logic sys_rst_n, soft_alarm, hard_alarm;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  clkwd_guard #(.RST_TICKS(RT)) u_clkwd_guard (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gear_rst_en(gear_rst_en),
    .fs_req(fs_req), .fs_latched(LAT), .fs_out(fs_out),
    .sys_rst_n(sys_rst_n), .soft_alarm(soft_alarm), .hard_alarm(hard_alarm)
  );

  function automatic logic [12:0] mk(input logic en, input logic s,
      input logic m, input logic [4:0] t, input logic [4:0] sel);
    return {en, s, m, t, sel};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic wcfg(input logic [12:0] v);
    cfg_wdata = v; cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_len(input string tag);
    int n = 0;
    while (!sys_rst_n && n < 40) begin pulse_tick(); n++; end
    check(tag, n, RT);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(1);
    // R1 defaults
    check("R1 cfg", cfg_rdata, 13'h0201);
    check("R1 rst_n", sys_rst_n, 1);
    check("R1 alarms", {soft_alarm, hard_alarm}, 0);
    check("R1 fs", fs_out, REQ0);

    // R2 disabled: ticks do nothing
    for (int i = 0; i < 40; i++) pulse_tick();
    check("R2 alarms", {soft_alarm, hard_alarm}, 0);
    check("R2 rst_n", sys_rst_n, 1);

    // table walk: R3 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [4:0] t, sel; logic s, m;
      int tt, n, nsoft;
      {t, s, m, sel} = VEC[v];
      tt = (t == 0) ? 1 : int'(t);
      wcfg(mk(1'b1, s, m, t, sel));
      check("R8 readback", cfg_rdata, mk(1'b1, s, m, t, sel));
      n = 0; nsoft = 0;
      while (!hard_alarm && n < 80) begin
        pulse_tick(); n++;
        if (soft_alarm && nsoft == 0) nsoft = n;
      end
      check(s ? "R5 hard ticks" : "R3 hard ticks", n, s ? 2 * tt : tt);
      if (s) check("R5 soft ticks", nsoft, tt);
      check("R6 rst low", sys_rst_n, 0);
      cyc(1);
      check("R7 safe fs", fs_out, m ? sel : LAT);
      pulse_len("R6 pulse");
      wcfg(mk(1'b0, s, m, t, sel));
      check("R8 cleared", {soft_alarm, hard_alarm}, 0);
      cyc(1);
      check("R8 fs back", fs_out, REQ0);
    end

    // R4 kick reload
    wcfg(mk(1'b1, 1'b0, 1'b0, 5'd3, 5'd1));
    pulse_tick(); pulse_tick(); pulse_kick();
    pulse_tick(); pulse_tick();
    check("R4 no alarm", hard_alarm, 0);
    pulse_tick();
    check("R4 alarm", hard_alarm, 1);

    // R10 sticky: kicks and ticks keep it, no new pulse
    pulse_len("R6 pulse kick");
    pulse_kick();
    for (int i = 0; i < 8; i++) pulse_tick();
    check("R10 sticky", hard_alarm, 1);
    check("R10 no repulse", sys_rst_n, 1);

    // R5 soft stage leaves reset high
    wcfg(mk(1'b1, 1'b1, 1'b0, 5'd2, 5'd1));
    pulse_tick(); pulse_tick();
    check("R5 soft only", {soft_alarm, hard_alarm, sys_rst_n}, 3'b101);
    wcfg(mk(1'b0, 1'b0, 1'b0, 5'd2, 5'd1));

    // R9 gear change with and without enable
    gear_rst_en = 1'b1;
    fs_req = 5'h04; cyc(1);
    check("R9 gear low", sys_rst_n, 0);
    check("R9 fs follows", fs_out, 5'h04);
    pulse_len("R9 pulse");
    gear_rst_en = 1'b0;
    fs_req = 5'h09; cyc(1);
    check("R9 no pulse", sys_rst_n, 1);
    check("R9 fs follows off", fs_out, 5'h09);
    cyc(4);
    check("R9 still high", sys_rst_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule